// File: doc/BRIEF.md
# Blitter DMA Slot Sequencer

This block chooses, one memory slot at a time, what a four-channel blitter does next. Three source channels (A, B, C) are read. A destination channel writes through a one-slot output pipeline. A 4-bit enable word selects which channels take part. Each enable combination has a fixed, repeating order of slot actions. The sequencer walks that order once per advance strobe and reports the action together with the number of whole passes already completed.

Ending a blit is deferred. A complete strobe only records which phase to enter once the running pattern reaches its last entry. From then on the sequencer asks for pipeline flushes until the next begin strobe. For some enable combinations, one idle slot is inserted before the flushes start.

The phase machine has three states:
- `PH_ONGOING`: the pattern is walked.
- `PH_PAUSE`: one idle slot, then `PH_DONE`.
- `PH_DONE`: the sequencer asks for a flush on every advance.

The transitions are:
- `ONGOING -> pending phase`, taken on the advance that emits the last pattern entry.
- `PAUSE -> DONE`, taken on any advance.
- `any -> ONGOING`, taken on a begin strobe.

The pending phase is `PH_ONGOING` after begin. A complete strobe sets it to `PH_PAUSE` or `PH_DONE`.

Top module: `blit_slot_seq`

## Requirements
- R1: After reset `slot_act` is 0 (idle), `pass_cnt` is 0, and the sequencer is in the done phase, so the first advance yields flush (2).
- R2: Enable bit 3 selects A, bit 2 selects B, bit 1 selects C and bit 0 selects the write. A pattern lists the enabled reads in the order A, B, C, then the write, then idle slots up to its length. The lengths for control values 0 to F are 1,2,2,3,3,3,3,4,2,2,2,3,3,3,3,4.
- R3: Actions are encoded 0 idle, 1 write, 2 flush, 3 read C, 4 read B, 5 read A. Each action is registered and appears the cycle after its advance strobe. In every cycle not following an accepted advance, `slot_act` is 0.
- R4: A begin strobe clears the pattern index and `pass_cnt`, and enters the ongoing phase with the pending phase set to ongoing. An advance in the same cycle as begin or a control load is ignored.
- R5: Loading a control value resets the pattern index to the first entry. It leaves `pass_cnt` and the phase unchanged, and a wrap that has not yet been counted is dropped.
- R6: `pass_cnt` increments by one on the first advance after the pattern wraps from its last entry. Otherwise it changes only on begin or reset.
- R7: A complete strobe does not alter the current pattern pass. The new phase takes effect only after the last entry has been emitted.
- R8: If control is 9, B or D when complete is strobed, exactly one idle slot follows the final pattern entry, then flushes follow. Any other control value goes straight to flushes.
- R9: In the done phase every advance yields flush, until a begin strobe.
- R10: A complete strobe in the same cycle as an advance updates the pending phase in time for that advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load `ctrl_in` into the enable register |
| ctrl_in | input | 4 | Channel-enable word (A, B, C, write from bit 3 down) |
| begin_i | input | 1 | Start a blit |
| complete_i | input | 1 | Request the end of the blit at the next pattern wrap |
| advance_i | input | 1 | Step to the next slot |
| slot_act | output | 3 | Encoded action for the slot just stepped |
| pass_cnt | output | PASS_W | Number of completed pattern passes |

## Verification
Both outputs are registered. An action and its matching pass count therefore appear together one clock after the advance, begin or load that caused them. The bench drives every strobe on a falling edge and holds it for one cycle. It samples both outputs at the following falling edge, which comes after exactly one rising edge. The table steps check every cycle, including cycles with no advance, where the action must read idle. Directed steps cover reset mid-run and a begin that collides with an advance. The mid-run reset is applied and released on falling edges, and the outputs are sampled a full cycle later.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    localparam int CTRL_W  = 4;
    localparam int MAX_PAT = 4;
    localparam int IDX_W   = $clog2(MAX_PAT);
    localparam int LEN_W   = IDX_W + 1;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_WRITE = 3'd1,
        ACT_FLUSH = 3'd2,
        ACT_RD_C  = 3'd3,
        ACT_RD_B  = 3'd4,
        ACT_RD_A  = 3'd5
    } slot_act_e;

    typedef enum logic [1:0] {
        PH_ONGOING = 2'd0,
        PH_PAUSE   = 2'd1,
        PH_DONE    = 2'd2
    } phase_e;

    // Number of slots in one pass of the pattern for a given enable word.
    function automatic logic [LEN_W-1:0] pat_len(input logic [CTRL_W-1:0] c);
        logic [LEN_W-1:0] r;
        unique case (c)
            4'h0:    r = LEN_W'(1);
            4'h1:    r = LEN_W'(2);
            4'h2:    r = LEN_W'(2);
            4'h3:    r = LEN_W'(3);
            4'h4:    r = LEN_W'(3);
            4'h5:    r = LEN_W'(3);
            4'h6:    r = LEN_W'(3);
            4'h7:    r = LEN_W'(4);
            4'h8:    r = LEN_W'(2);
            4'h9:    r = LEN_W'(2);
            4'hA:    r = LEN_W'(2);
            4'hB:    r = LEN_W'(3);
            4'hC:    r = LEN_W'(3);
            4'hD:    r = LEN_W'(3);
            4'hE:    r = LEN_W'(3);
            default: r = LEN_W'(4);
        endcase
        return r;
    endfunction

    // Enable words whose end needs one idle slot before the flushes.
    function automatic logic needs_pause(input logic [CTRL_W-1:0] c);
        return (c == 4'h9) || (c == 4'hB) || (c == 4'hD);
    endfunction

endpackage

// File: rtl/slot_pattern_lut.sv
module slot_pattern_lut
    import blit_seq_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [IDX_W-1:0]  idx_i,
    output slot_act_e         act_o,
    output logic              last_o
);

    localparam int NCH = CTRL_W;

    slot_act_e        seq [MAX_PAT];
    slot_act_e        ch_act [NCH];
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] fill;

    // Channel identity for each enable bit, bit 0 being the write.
    generate
        for (genvar b = 0; b < NCH; b++) begin : g_ch
            if (b == 3)      begin : g_a assign ch_act[b] = ACT_RD_A;  end
            else if (b == 2) begin : g_b assign ch_act[b] = ACT_RD_B;  end
            else if (b == 1) begin : g_c assign ch_act[b] = ACT_RD_C;  end
            else             begin : g_w assign ch_act[b] = ACT_WRITE; end
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < MAX_PAT; k++) begin
            seq[k] = ACT_IDLE;
        end
        fill = '0;
        for (int b = NCH - 1; b >= 0; b--) begin
            if (ctrl_i[b]) begin
                seq[fill[IDX_W-1:0]] = ch_act[b];
                fill = fill + 1'b1;
            end
        end
    end

    assign len    = pat_len(ctrl_i);
    assign act_o  = seq[idx_i];
    assign last_o = ({1'b0, idx_i} == (len - 1'b1));

endmodule

// File: rtl/slot_index_ctr.sv
module slot_index_ctr
    import blit_seq_pkg::*;
#(
    parameter int PASS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_idx,
    input  logic              step,
    input  logic              last,
    output logic [IDX_W-1:0]  idx,
    output logic [PASS_W-1:0] pass
);

    logic wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            pass   <= '0;
            wrap_q <= 1'b0;
        end else if (clr_all) begin
            idx    <= '0;
            pass   <= '0;
            wrap_q <= 1'b0;
        end else if (clr_idx) begin
            idx    <= '0;
            wrap_q <= 1'b0;
        end else if (step) begin
            if (wrap_q) begin
                pass <= pass + 1'b1;
            end
            if (last) begin
                idx    <= '0;
                wrap_q <= 1'b1;
            end else begin
                idx    <= idx + 1'b1;
                wrap_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
    import blit_seq_pkg::*;
#(
    parameter int PASS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [3:0]        ctrl_in,
    input  logic              begin_i,
    input  logic              complete_i,
    input  logic              advance_i,
    output logic [2:0]        slot_act,
    output logic [PASS_W-1:0] pass_cnt
);

    logic [CTRL_W-1:0] ctrl_q;
    phase_e            phase_q, phase_d;
    phase_e            pend_q, pend_eff;
    slot_act_e         act_q, act_d, lut_act;
    logic              lut_last;
    logic [IDX_W-1:0]  idx;
    logic              adv_ok;
    logic              step_ptn;

    assign adv_ok   = advance_i && !begin_i && !ctrl_we;
    assign step_ptn = adv_ok && (phase_q == PH_ONGOING);

    always_comb begin
        pend_eff = pend_q;
        if (complete_i && !begin_i) begin
            pend_eff = needs_pause(ctrl_q) ? PH_PAUSE : PH_DONE;
        end
    end

    slot_pattern_lut u_lut (
        .ctrl_i (ctrl_q),
        .idx_i  (idx),
        .act_o  (lut_act),
        .last_o (lut_last)
    );

    slot_index_ctr #(.PASS_W(PASS_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (begin_i),
        .clr_idx (ctrl_we),
        .step    (step_ptn),
        .last    (lut_last),
        .idx     (idx),
        .pass    (pass_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_in;
        end
    end

    // Next phase
    always_comb begin
        phase_d = phase_q;
        if (begin_i) begin
            phase_d = PH_ONGOING;
        end else if (adv_ok) begin
            unique case (phase_q)
                PH_ONGOING: if (lut_last) phase_d = pend_eff;
                PH_PAUSE:   phase_d = PH_DONE;
                PH_DONE:    phase_d = PH_DONE;
                default:    phase_d = PH_DONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DONE;
            pend_q  <= PH_DONE;
        end else begin
            phase_q <= phase_d;
            pend_q  <= begin_i ? PH_ONGOING : pend_eff;
        end
    end

    // Output action
    always_comb begin
        act_d = ACT_IDLE;
        if (adv_ok) begin
            unique case (phase_q)
                PH_ONGOING: act_d = lut_act;
                PH_PAUSE:   act_d = ACT_IDLE;
                PH_DONE:    act_d = ACT_FLUSH;
                default:    act_d = ACT_FLUSH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= ACT_IDLE;
        end else begin
            act_q <= act_d;
        end
    end

    assign slot_act = act_q;

endmodule

// File: rtl/blit_slot_seq_chk.sv
module blit_slot_seq_chk
    import blit_seq_pkg::*;
#(
    parameter int PASS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic              begin_i,
    input logic              advance_i,
    input logic [2:0]        slot_act,
    input logic [PASS_W-1:0] pass_cnt,
    input phase_e            phase_q
);

    // R3
    no_adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> (slot_act == 3'd0));

    // R3
    act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_act <= 3'd5);

    // R4
    begin_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        begin_i |=> (pass_cnt == '0));

    // R6
    pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !begin_i |=> (pass_cnt == $past(pass_cnt)) ||
                     (pass_cnt == PASS_W'($past(pass_cnt) + 1'b1)));

    // R5
    load_keeps_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !begin_i) |=> $stable(pass_cnt));

    // R8
    pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PAUSE && advance_i && !begin_i && !ctrl_we) |=> (slot_act == 3'd0));

    // R9
    done_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE && advance_i && !begin_i && !ctrl_we) |=> (slot_act == 3'd2));

endmodule

bind blit_slot_seq blit_slot_seq_chk #(.PASS_W(PASS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .begin_i   (begin_i),
    .advance_i (advance_i),
    .slot_act  (slot_act),
    .pass_cnt  (pass_cnt),
    .phase_q   (phase_q)
);

// File: tb/sim_blit_slot_seq.sv
module sim_blit_slot_seq;

    localparam int PASS_W = 8;
    localparam int NV     = 59;

    // ops
    localparam logic [2:0] OP_ADV  = 3'd0;
    localparam logic [2:0] OP_LOAD = 3'd1;
    localparam logic [2:0] OP_CPL  = 3'd3;
    localparam logic [2:0] OP_CADV = 3'd4;
    localparam logic [2:0] OP_LDBG = 3'd5;

    // {op, data, expected action, expected pass}
    localparam logic [17:0] VEC [NV] = '{
        {OP_ADV , 4'h0, 3'd2, 8'd0},   // 0  R1 done after reset
        {OP_LDBG, 4'hF, 3'd0, 8'd0},   // 1
        {OP_ADV , 4'h0, 3'd5, 8'd0},   // 2  R2
        {OP_ADV , 4'h0, 3'd4, 8'd0},
        {OP_ADV , 4'h0, 3'd3, 8'd0},
        {OP_ADV , 4'h0, 3'd1, 8'd0},
        {OP_ADV , 4'h0, 3'd5, 8'd1},   // 6  R6
        {OP_CPL , 4'h0, 3'd0, 8'd1},   // 7  R7
        {OP_ADV , 4'h0, 3'd4, 8'd1},
        {OP_ADV , 4'h0, 3'd3, 8'd1},
        {OP_ADV , 4'h0, 3'd1, 8'd1},
        {OP_ADV , 4'h0, 3'd2, 8'd1},   // 11 R9
        {OP_ADV , 4'h0, 3'd2, 8'd1},
        {OP_LDBG, 4'h9, 3'd0, 8'd0},   // 13 R4
        {OP_ADV , 4'h0, 3'd5, 8'd0},
        {OP_ADV , 4'h0, 3'd1, 8'd0},
        {OP_CADV, 4'h0, 3'd5, 8'd1},   // 16 R10
        {OP_ADV , 4'h0, 3'd1, 8'd1},
        {OP_ADV , 4'h0, 3'd0, 8'd1},   // 18 R8 pause
        {OP_ADV , 4'h0, 3'd2, 8'd1},
        {OP_LDBG, 4'h4, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd4, 8'd0},   // 21 R2 padding
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd4, 8'd1},
        {OP_LOAD, 4'h5, 3'd0, 8'd1},   // 25 R5
        {OP_ADV , 4'h0, 3'd4, 8'd1},
        {OP_ADV , 4'h0, 3'd1, 8'd1},
        {OP_ADV , 4'h0, 3'd0, 8'd1},
        {OP_ADV , 4'h0, 3'd4, 8'd2},
        {OP_LDBG, 4'hD, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd5, 8'd0},
        {OP_ADV , 4'h0, 3'd4, 8'd0},
        {OP_CPL , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd1, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},   // 35 R8
        {OP_ADV , 4'h0, 3'd2, 8'd0},
        {OP_LDBG, 4'hC, 3'd0, 8'd0},
        {OP_CPL , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd5, 8'd0},
        {OP_ADV , 4'h0, 3'd4, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd2, 8'd0},   // 42 R8 no pause for C
        {OP_LDBG, 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd1},
        {OP_ADV , 4'h0, 3'd0, 8'd2},
        {OP_LDBG, 4'hB, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd5, 8'd0},
        {OP_ADV , 4'h0, 3'd3, 8'd0},
        {OP_CPL , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd1, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd2, 8'd0},
        {OP_LDBG, 4'h3, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd3, 8'd0},
        {OP_ADV , 4'h0, 3'd1, 8'd0},
        {OP_ADV , 4'h0, 3'd0, 8'd0},
        {OP_ADV , 4'h0, 3'd3, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_we = 1'b0;
    logic [3:0]        ctrl_in = '0;
    logic              begin_i = 1'b0;
    logic              complete_i = 1'b0;
    logic              advance_i = 1'b0;
    logic [2:0]        slot_act;
    logic [PASS_W-1:0] pass_cnt;

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    blit_slot_seq #(.PASS_W(PASS_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_in    (ctrl_in),
        .begin_i    (begin_i),
        .complete_i (complete_i),
        .advance_i  (advance_i),
        .slot_act   (slot_act),
        .pass_cnt   (pass_cnt)
    );

    task automatic check(input string req, input logic [2:0] ea, input logic [7:0] ep);
        n_run++;
        if (slot_act !== ea || pass_cnt !== ep) begin
            n_fail++;
            $display("FAIL %s: act=%0d pass=%0d expected act=%0d pass=%0d",
                     req, slot_act, pass_cnt, ea, ep);
        end
    endtask

    // Called at a falling edge: drive for one cycle, sample at the next falling edge.
    task automatic step(input logic [2:0] op, input logic [3:0] d);
        ctrl_we    = (op == OP_LOAD) || (op == OP_LDBG);
        ctrl_in    = d;
        begin_i    = (op == OP_LDBG);
        complete_i = (op == OP_CPL) || (op == OP_CADV);
        advance_i  = (op == OP_ADV) || (op == OP_CADV);
        @(negedge clk);
        ctrl_we = 1'b0; begin_i = 1'b0; complete_i = 1'b0; advance_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 3'd0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:15], VEC[i][14:11]);
            check($sformatf("R2/R3/R6 vector %0d", i), VEC[i][10:8], VEC[i][7:0]);
        end

        // R4: an advance colliding with begin is ignored
        ctrl_in = 4'hE; ctrl_we = 1'b1; begin_i = 1'b1; advance_i = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0; begin_i = 1'b0; advance_i = 1'b0;
        check("R4 begin+advance ignored", 3'd0, 8'd0);
        step(OP_ADV, 4'h0);
        check("R4 first slot after begin", 3'd5, 8'd0);
        step(OP_ADV, 4'h0);
        check("R2 pattern E second", 3'd4, 8'd0);

        // R1: reset mid-run returns to the done phase
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset mid-run", 3'd0, 8'd0);
        step(OP_ADV, 4'h0);
        check("R1 flush after reset", 3'd2, 8'd0);
        step(OP_ADV, 4'h0);
        check("R9 flush repeats", 3'd2, 8'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: act=%0d pass=%0d expected completion", slot_act, pass_cnt);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule